// File: doc/BRIEF.md
# Flash Command and Status Controller

This block is the register front end of a page-programmed embedded flash. Software fills a page buffer one 32-bit word at a time. It then writes a command word that carries a key, a page or bit number, and an opcode. The controller checks the key, the opcode, the argument range and the lock state. A command that fails a check ends at once with an error flag. An accepted command holds the ready flag low for a busy period set by the mode register. The operation then takes effect on the array, the lock bits or the general-purpose NVM bits. The array is a behavioural RAM inside the block.

The register side uses a word-addressed bus whose top address bit selects the array window. When that bit is clear, the low two bits pick a register: 0 is mode, 1 is command and 2 is status. When the top bit is set, a write goes to the page buffer word given by the low word-index bits, and a read returns the array word at the flat word address (page number times words per page, plus word index). Reads are combinational on the address. A status read clears its sticky flags at the clock edge that ends the read cycle.

The status word is laid out as follows:
- bit 0: ready
- bit 1: lock operation finished
- bit 2: lock error
- bit 3: invalid command
- bit 4: security, always 0
- bits from 8 upward: NVM bits
- bits from 16 upward: one lock bit per region

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, status reads 0x00000001 (ready only), the mode register reads 0, and every array word reads 0xFFFFFFFF.
- R2: A command word is bits [31:24] key, [23:8] argument, [7:0] opcode. The key must be 0x5A. The opcodes are 0x01 page write, 0x02 lock, 0x04 unlock, 0x08 erase all, 0x0B NVM set and 0x0D NVM clear. A bad key, an unknown opcode, or a page argument at or above the page count sets status bit 3, keeps ready high and changes nothing.
- R3: Status bit 2 is set, ready stays high and nothing changes in three cases: a page write to a page in a locked region, a lock command on a region that is already locked, or erase all while any lock bit is set.
- R4: Ready (status bit 0) drops in the cycle after an accepted command and stays low for exactly FMCN+1 cycles, where FMCN is mode bits [23:16].
- R5: A command written while ready is low is ignored. It raises no error and has no effect.
- R6: A lock or unlock command selects region argument/PAGES_PER_REGION. On completion it sets or clears status bit 16+region and sets status bit 1.
- R7: NVM set and clear change status bit 8+argument. An argument at or above NVM_BITS is an invalid command.
- R8: A page write copies the page buffer into the addressed page. Buffer words not loaded since the last page write read back 0xFFFFFFFF. Buffer writes while busy are dropped.
- R9: Erase all makes every array word read 0xFFFFFFFF.
- R10: A status read returns the current flags and then clears bits 1, 2 and 3.
- R11: The mode register reads back bits [23:16] and bit 8 as written. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; needed for the status clear-on-read |
| bus_addr | input | 12 | Word address; top bit selects the array window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |

## Verification
The hardest situation to reach is a second command landing inside the busy window. It must be dropped silently, with no error flag and no lock change. To get there, the bench writes a lock command and, on the very next cycle, writes a bad-key word and a lock command for another region. It then checks that only the first region ended up locked and that no error bit was raised. The automatic page erase also needs two page writes to the same page with disjoint buffer words, so that a stale word would show up if the buffer were not refilled.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam logic [7:0] CMD_KEY    = 8'h5A;
  localparam logic [7:0] OPC_WRITE  = 8'h01;
  localparam logic [7:0] OPC_LOCK   = 8'h02;
  localparam logic [7:0] OPC_UNLOCK = 8'h04;
  localparam logic [7:0] OPC_ERASE  = 8'h08;
  localparam logic [7:0] OPC_NVSET  = 8'h0B;
  localparam logic [7:0] OPC_NVCLR  = 8'h0D;

  typedef enum logic [2:0] {
    K_NONE, K_WRITE, K_LOCK, K_UNLOCK, K_ERASE, K_NVSET, K_NVCLR
  } kind_e;

  localparam int ST_READY = 0;
  localparam int ST_EOL   = 1;
  localparam int ST_LERR  = 2;
  localparam int ST_CERR  = 3;
  localparam int ST_NVM   = 8;
  localparam int ST_LOCK  = 16;
endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
  import flash_pkg::*;
#(
  parameter int NUM_PAGES        = 64,
  parameter int PAGES_PER_REGION = 32,
  parameter int NUM_REGIONS      = 2,
  parameter int NVM_BITS         = 2,
  localparam int PB  = $clog2(NUM_PAGES),
  localparam int RW  = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int NVW = (NVM_BITS > 1) ? $clog2(NVM_BITS) : 1
) (
  input  logic [31:0]            cmd_word,
  input  logic [NUM_REGIONS-1:0] locks,
  output kind_e                  kind,
  output logic [PB-1:0]          page,
  output logic [RW-1:0]          region,
  output logic [NVW-1:0]         nv_idx,
  output logic                   bad_cmd,
  output logic                   lock_err
);
  logic [15:0] arg;
  logic [15:0] reg_full;
  logic        page_ok, nv_ok, key_ok, locked;

  assign arg      = cmd_word[23:8];
  assign key_ok   = (cmd_word[31:24] == CMD_KEY);
  assign page_ok  = (arg < 16'(NUM_PAGES));
  assign nv_ok    = (arg < 16'(NVM_BITS));
  assign reg_full = arg / 16'(PAGES_PER_REGION);
  assign region   = reg_full[RW-1:0];
  assign page     = arg[PB-1:0];
  assign nv_idx   = arg[NVW-1:0];
  assign locked   = page_ok && locks[region];

  always_comb begin
    kind    = K_NONE;
    bad_cmd = 1'b0;
    unique case (cmd_word[7:0])
      OPC_WRITE:  kind = K_WRITE;
      OPC_LOCK:   kind = K_LOCK;
      OPC_UNLOCK: kind = K_UNLOCK;
      OPC_ERASE:  kind = K_ERASE;
      OPC_NVSET:  kind = K_NVSET;
      OPC_NVCLR:  kind = K_NVCLR;
      default:    bad_cmd = 1'b1;
    endcase
    if (!key_ok) bad_cmd = 1'b1;
    if ((kind == K_WRITE || kind == K_LOCK || kind == K_UNLOCK) && !page_ok) bad_cmd = 1'b1;
    if ((kind == K_NVSET || kind == K_NVCLR) && !nv_ok) bad_cmd = 1'b1;
  end

  always_comb begin
    unique case (kind)
      K_WRITE, K_LOCK: lock_err = locked;
      K_ERASE:         lock_err = |locks;
      default:         lock_err = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcc_timer.sv
module fcc_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy,
  output logic          done
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = load;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/fcc_store.sv
module fcc_store #(
  parameter int WORDS     = 32,
  parameter int NUM_PAGES = 64,
  localparam int WB = $clog2(WORDS),
  localparam int PB = $clog2(NUM_PAGES),
  localparam int MA = WB + PB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_we,
  input  logic [WB-1:0] buf_idx,
  input  logic [31:0]   buf_data,
  input  logic          commit,
  input  logic [PB-1:0] commit_page,
  input  logic          erase,
  input  logic [MA-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  logic [31:0]          buf_q [WORDS];
  logic [31:0]          mem_q [WORDS*NUM_PAGES];
  logic [NUM_PAGES-1:0] ok_q, ok_d;

  // Page buffer: refilled with ones after each page write (automatic erase).
  for (genvar g = 0; g < WORDS; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[g] <= '1;
      end else if (commit) begin
        buf_q[g] <= '1;
      end else if (buf_we && buf_idx == WB'(g)) begin
        buf_q[g] <= buf_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int w = 0; w < WORDS; w++) begin
        mem_q[{commit_page, WB'(w)}] <= buf_q[w];
      end
    end
  end

  always_comb begin
    ok_d = ok_q;
    if (erase) ok_d = '0;
    else if (commit) ok_d[commit_page] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= '0;
    else        ok_q <= ok_d;
  end

  assign rd_data = ok_q[rd_addr[MA-1:WB]] ? mem_q[rd_addr] : '1;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int PAGE_BYTES       = 128,
  parameter int PAGES_PER_REGION = 32,
  parameter int NUM_REGIONS      = 2,
  parameter int NVM_BITS         = 2,
  localparam int WORDS     = PAGE_BYTES / 4,
  localparam int NUM_PAGES = PAGES_PER_REGION * NUM_REGIONS,
  localparam int WB        = $clog2(WORDS),
  localparam int PB        = $clog2(NUM_PAGES),
  localparam int MA        = WB + PB,
  localparam int AW        = MA + 1,
  localparam int RW        = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int NVW       = (NVM_BITS > 1) ? $clog2(NVM_BITS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata
);
  // Reset synchroniser: asynchronous assertion, synchronous release.
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  logic mem_sel, cmd_wr, stat_rd, mode_wr, accept, busy, done, bad_cmd, lock_err;
  logic [1:0] reg_idx;
  kind_e kind, kind_q;
  logic [PB-1:0]  page, page_q;
  logic [RW-1:0]  region, region_q;
  logic [NVW-1:0] nv_idx, nv_q;
  logic [7:0] fmcn_q;
  logic       ws_q;
  logic       eol_q, eol_d, lerr_q, lerr_d, cerr_q, cerr_d;
  logic [NUM_REGIONS-1:0] locks_q, locks_d;
  logic [NVM_BITS-1:0]    nvm_q, nvm_d;
  logic [31:0] stat, store_rd;

  assign mem_sel = bus_addr[AW-1];
  assign reg_idx = bus_addr[1:0];
  assign mode_wr = bus_wr && !mem_sel && reg_idx == 2'd0;
  assign cmd_wr  = bus_wr && !mem_sel && reg_idx == 2'd1;
  assign stat_rd = bus_rd && !mem_sel && reg_idx == 2'd2;
  assign accept  = cmd_wr && !busy && !bad_cmd && !lock_err;

  fcc_decode #(.NUM_PAGES(NUM_PAGES), .PAGES_PER_REGION(PAGES_PER_REGION),
               .NUM_REGIONS(NUM_REGIONS), .NVM_BITS(NVM_BITS)) u_dec (
    .cmd_word(bus_wdata), .locks(locks_q), .kind(kind), .page(page),
    .region(region), .nv_idx(nv_idx), .bad_cmd(bad_cmd), .lock_err(lock_err));

  fcc_timer #(.CW(8)) u_tmr (
    .clk(clk), .rst_n(rst_q), .start(accept), .load(fmcn_q), .busy(busy), .done(done));

  fcc_store #(.WORDS(WORDS), .NUM_PAGES(NUM_PAGES)) u_store (
    .clk(clk), .rst_n(rst_q),
    .buf_we(bus_wr && mem_sel && !busy), .buf_idx(bus_addr[WB-1:0]), .buf_data(bus_wdata),
    .commit(done && kind_q == K_WRITE), .commit_page(page_q),
    .erase(done && kind_q == K_ERASE), .rd_addr(bus_addr[MA-1:0]), .rd_data(store_rd));

  always_comb begin
    stat                          = '0;
    stat[ST_READY]                = !busy;
    stat[ST_EOL]                  = eol_q;
    stat[ST_LERR]                 = lerr_q;
    stat[ST_CERR]                 = cerr_q;
    stat[ST_NVM +: NVM_BITS]      = nvm_q;
    stat[ST_LOCK +: NUM_REGIONS]  = locks_q;
  end

  always_comb begin
    if (mem_sel) bus_rdata = store_rd;
    else begin
      unique case (reg_idx)
        2'd0:    bus_rdata = {8'h00, fmcn_q, 7'h00, ws_q, 8'h00};
        2'd2:    bus_rdata = stat;
        default: bus_rdata = '0;
      endcase
    end
  end

  // Next-state for flags, lock bits and NVM bits.
  always_comb begin
    cerr_d  = cerr_q;
    lerr_d  = lerr_q;
    eol_d   = eol_q;
    locks_d = locks_q;
    nvm_d   = nvm_q;
    if (stat_rd) begin
      cerr_d = 1'b0;
      lerr_d = 1'b0;
      eol_d  = 1'b0;
    end
    if (cmd_wr && !busy && bad_cmd)                   cerr_d = 1'b1;
    else if (cmd_wr && !busy && lock_err)             lerr_d = 1'b1;
    if (accept) eol_d = 1'b0;
    if (done) begin
      unique case (kind_q)
        K_LOCK:   begin locks_d[region_q] = 1'b1; eol_d = 1'b1; end
        K_UNLOCK: begin locks_d[region_q] = 1'b0; eol_d = 1'b1; end
        K_NVSET:  nvm_d[nv_q] = 1'b1;
        K_NVCLR:  nvm_d[nv_q] = 1'b0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cerr_q  <= 1'b0;
      lerr_q  <= 1'b0;
      eol_q   <= 1'b0;
      locks_q <= '0;
      nvm_q   <= '0;
    end else begin
      cerr_q  <= cerr_d;
      lerr_q  <= lerr_d;
      eol_q   <= eol_d;
      locks_q <= locks_d;
      nvm_q   <= nvm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      fmcn_q <= '0;
      ws_q   <= 1'b0;
    end else if (mode_wr) begin
      fmcn_q <= bus_wdata[23:16];
      ws_q   <= bus_wdata[8];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      kind_q   <= K_NONE;
      page_q   <= '0;
      region_q <= '0;
      nv_q     <= '0;
    end else if (accept) begin
      kind_q   <= kind;
      page_q   <= page;
      region_q <= region;
      nv_q     <= nv_idx;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int NUM_REGIONS = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        stat_rd,
  input logic [31:0] cmd_word,
  input logic [31:0] stat
);
  // R2
  bad_key_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && stat[0] && cmd_word[31:24] != 8'h5A) |=> (stat[3] && stat[0]));

  // R5
  busy_no_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[0] |=> (!$rose(stat[3]) && !$rose(stat[2])));

  // R6
  lock_change_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat[16 +: NUM_REGIONS]) |-> $rose(stat[0]));

  // R6
  eol_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> $rose(stat[0]));

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cmd_wr) |=> (!stat[1] && !stat[2] && !stat[3]));

  // R3
  lock_err_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[2]) |-> (stat[0] && $past(stat[0])));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk(clk), .rst_n(rst_q), .cmd_wr(cmd_wr), .stat_rd(stat_rd),
  .cmd_word(bus_wdata), .stat(stat));

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int AW       = 12;
  localparam int MEMBASE  = 1 << (AW - 1);
  localparam int A_MODE   = 0;
  localparam int A_CMD    = 1;
  localparam int A_STAT   = 2;
  localparam int FMCN     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = AW'(A_STAT);
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_cmd_ctrl u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // {command word, expected status after completion}
  localparam logic [63:0] VEC [12] = '{
    {32'h5B000008, 32'h00000009},  // R2 bad key
    {32'h5A000007, 32'h00000009},  // R2 unknown opcode
    {32'h5A000002, 32'h00010003},  // R6 lock region 0
    {32'h5A002001, 32'h00010001},  // R8 write page 32 (region 1)
    {32'h5A000501, 32'h00010005},  // R3 write into locked region
    {32'h5A000008, 32'h00010005},  // R3 erase all with a lock set
    {32'h5A000002, 32'h00010005},  // R3 lock an already locked region
    {32'h5A000004, 32'h00000003},  // R6 unlock region 0
    {32'h5A00010B, 32'h00000201},  // R7 set NVM bit 1
    {32'h5A00050B, 32'h00000209},  // R7 NVM index out of range
    {32'h5A00010D, 32'h00000001},  // R7 clear NVM bit 1
    {32'h5A004001, 32'h00000009}   // R2 page out of range
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = AW'(A_STAT);
  endtask

  task automatic peek(input int addr, output logic [31:0] data);
    bus_addr = AW'(addr);
    #1 data = bus_rdata;
    bus_addr = AW'(A_STAT);
  endtask

  task automatic read_status(output logic [31:0] data);
    @(negedge clk);
    bus_addr = AW'(A_STAT); bus_rd = 1'b1;
    #1 data = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    for (int i = 0; i < 1000; i++) begin
      peek(A_STAT, s);
      if (s[0]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(A_STAT, s);            check("R1 status", s, 32'h00000001);
    peek(A_MODE, s);            check("R1 mode", s, 32'h0);
    peek(MEMBASE + 5, s);       check("R1 array", s, 32'hFFFFFFFF);

    // R11 mode readback
    wr(A_MODE, 32'hFF03_FF00 | (FMCN << 16));
    peek(A_MODE, s);            check("R11 mode", s, 32'h0003_0100);

    // R4 busy length
    wr(A_CMD, 32'h5A000008);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      peek(A_STAT, s);
      if (s[0]) break;
      cnt++;
      @(negedge clk);
    end
    check("R4 busy cycles", 32'(cnt), 32'(FMCN + 1));
    read_status(s);

    // Table walk
    foreach (VEC[k]) begin
      wr(A_CMD, VEC[k][63:32]);
      wait_ready();
      read_status(s);
      check($sformatf("R2/R3/R6/R7 vector %0d", k), s, VEC[k][31:0]);
    end

    // R10 flags cleared by the read
    wr(A_CMD, 32'h00000001);
    read_status(s);             check("R10 read value", s, 32'h00000009);
    peek(A_STAT, s);            check("R10 cleared", s, 32'h00000001);

    // R8 page write and automatic erase
    wr(MEMBASE + 0, 32'h11111111);
    wr(MEMBASE + 3, 32'h33333333);
    wr(A_CMD, 32'h5A000201);
    wait_ready();
    peek(MEMBASE + 64, s);      check("R8 word0", s, 32'h11111111);
    peek(MEMBASE + 67, s);      check("R8 word3", s, 32'h33333333);
    peek(MEMBASE + 65, s);      check("R8 unloaded", s, 32'hFFFFFFFF);
    wr(MEMBASE + 1, 32'hAAAA5555);
    wr(A_CMD, 32'h5A000201);
    wr(MEMBASE + 2, 32'h12345678);  // dropped: busy
    wait_ready();
    peek(MEMBASE + 64, s);      check("R8 auto erase", s, 32'hFFFFFFFF);
    peek(MEMBASE + 65, s);      check("R8 rewrite", s, 32'hAAAA5555);
    peek(MEMBASE + 66, s);      check("R8 busy buffer write", s, 32'hFFFFFFFF);

    // R9 erase all
    wr(A_CMD, 32'h5A000008);
    wait_ready();
    peek(MEMBASE + 65, s);      check("R9 erased", s, 32'hFFFFFFFF);
    peek(MEMBASE + 1024, s);    check("R9 page32 erased", s, 32'hFFFFFFFF);

    // R5 commands while busy are ignored
    read_status(s);
    wr(A_CMD, 32'h5A002102);
    wr(A_CMD, 32'h00000000);
    wr(A_CMD, 32'h5A000002);
    wait_ready();
    read_status(s);             check("R5 busy ignore", s, 32'h00020003);
    wr(A_CMD, 32'h5A002104);
    wait_ready();
    read_status(s);             check("R6 unlock region 1", s, 32'h00000003);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule